// File: doc/BRIEF.md
# Supply Voltage Supervisor Control

This block is the digital side of a supply supervisor in a small microcontroller. Three analog comparators report three conditions: the supply is under the power-on re-arm level, under the high trip level, or under the low trip level. A two-flop synchronizer brings each of these flags into the clock domain. A state machine then decides three things:

- when to hold the system in reset;
- when to raise a low-voltage interrupt;
- which low-power mode a stop request really enters.

Software programs the detector through a small register bus:

| Address | Contents |
|---|---|
| 0 | Control byte |
| 1 | Threshold select |
| 2 | Reset cause (read-only) |

Each reset is held until its cause goes away, not for a fixed count. A power-on reset lasts until the supply is above the low trip level. A low-voltage reset lasts until the supply is above the selected level. An external reset lasts while its request input is high.

The state machine has five states:

| State | Meaning |
|---|---|
| ST_POR_HOLD | Power-on reset hold (the reset state) |
| ST_LVD_HOLD | Low-voltage reset hold |
| ST_EXT_HOLD | External reset hold |
| ST_RUN | Normal running |
| ST_STOP | Low-power stop |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_REARM | any state | ST_POR_HOLD | Synchronized re-arm flag is high; this has the highest priority |
| T_POR_DONE | ST_POR_HOLD | ST_RUN | Synchronized low flag is clear |
| T_LVD_DONE | ST_LVD_HOLD | ST_RUN | Selected flag is clear |
| T_EXT_DONE | ST_EXT_HOLD | ST_RUN | External request is low |
| T_LVD_TRIP | ST_RUN or ST_STOP | ST_LVD_HOLD | A detection occurs while reset-enable is set |
| T_EXT_TRIP | ST_RUN or ST_STOP | ST_EXT_HOLD | External request is high; lower priority than T_LVD_TRIP |
| T_STOP | ST_RUN | ST_STOP | A stop request arrives |
| T_WAKE | ST_STOP | ST_RUN | A wake pulse arrives |

Top module: `vsup_ctrl`

## Requirements
- R1: A detection is the rising edge of the selected synchronized below-threshold flag while the detector is on. With reset-enable set, `sys_rst_o` rises on the third clock edge after the comparator input rises. A below level held steady never triggers again.
- R2: Threshold select register (address 1) bit 0 chooses the comparator: 1 selects the high trip comparator, 0 selects the low trip comparator. The comparator that is not selected has no effect.
- R3: The detector is on only while detect-enable (address 0, bit 0) is set. `det_on_o` shows this. With detect-enable clear, a comparator edge raises neither reset nor interrupt.
- R4: `lp_mode_o` uses 0=run, 1=stop2, 2=stop3, 3=stop4. `stop_depth_i` uses 0=stop2, 1=stop3, 2 or 3=stop4. If stop-keep (address 0, bit 3) or detect-enable is clear, a stop2 or stop3 request enters that mode with the detector off.
- R5: If detect-enable and stop-keep are both set, a stop2 or stop3 request enters stop4 instead, and the detector stays on. A stop4 request always enters stop4. A detection in stop4 with reset-enable set resets the device.
- R6: Power-up (`rst_ni` low) or a synchronized re-arm flag holds reset. The hold lasts until both the re-arm and low trip flags are clear. While it lasts, the controls return to detect-enable=1, reset-enable=1 and all other bits 0.
- R7: A low-voltage reset holds `sys_rst_o` high until the selected synchronized flag clears.
- R8: The cause register (address 2) has power-on in bit 2, low-voltage in bit 1 and external in bit 0. A power-on reset reads 6, a low-voltage reset reads 2 and an external reset reads 1. Each reset replaces the old value. Software cannot write it.
- R9: A detection sets the sticky flag (address 0, bit 7) when interrupt-enable (address 0, bit 2) is set and reset-enable (address 0, bit 1) is clear. `irq_o` is the flag ANDed with interrupt-enable. Any reset clears the flag.
- R10: Writing 1 to the acknowledge bit (address 0, bit 6) clears the flag. The acknowledge bit always reads 0.
- R11: `ext_rst_req_i` in run or stop holds reset while it stays high, with cause 1. A low-voltage trip in the same cycle takes priority.
- R12: In stop, a `wake_i` pulse returns to run. During reset, `lp_mode_o` reads 0.
- R13: Bus writes are ignored while `sys_rst_o` is high. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| cmp_below_rearm_i | input | 1 | Supply under the power-on re-arm level |
| cmp_below_hi_i | input | 1 | Supply under the high trip level |
| cmp_below_lo_i | input | 1 | Supply under the low trip level |
| ext_rst_req_i | input | 1 | External reset request, held high |
| stop_req_i | input | 1 | Stop request strobe |
| stop_depth_i | input | 2 | Requested stop depth |
| wake_i | input | 1 | Wake pulse that leaves stop |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Low-voltage interrupt request |
| sys_rst_o | output | 1 | System reset, active high |
| lp_mode_o | output | 2 | Current low-power mode |
| det_on_o | output | 1 | Detector currently active |

## Verification
A wrong state register shows at the ports in the same cycle as a wrong `sys_rst_o` or `lp_mode_o` value. A stale edge-detect register or a bad synchronizer stage shows as a reset or interrupt arriving one cycle early or late, or arriving twice for one held level. The bench detects these because it compares every output on every cycle against an independent cycle model. A corrupted control or cause register stays hidden until it is read back, or until it changes a later stop-mode or detection decision. For this reason the bench reads every register after each reset and each mode change.

// File: rtl/vsup_pkg.sv
package vsup_pkg;
    localparam int BUS_DW = 8;
    localparam int N_CMP = 3;
    localparam int CMP_REARM = 0;
    localparam int CMP_HI = 1;
    localparam int CMP_LO = 2;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_SEL = 2'd1;
    localparam logic [1:0] ADR_CAUSE = 2'd2;

    localparam int B_DET_EN = 0;
    localparam int B_RST_EN = 1;
    localparam int B_IRQ_EN = 2;
    localparam int B_KEEP = 3;
    localparam int B_ACK = 6;
    localparam int B_FLAG = 7;

    localparam logic [2:0] CAUSE_POR = 3'b110;
    localparam logic [2:0] CAUSE_LVD = 3'b010;
    localparam logic [2:0] CAUSE_EXT = 3'b001;

    typedef enum logic [2:0] {
        ST_POR_HOLD = 3'd0,
        ST_LVD_HOLD = 3'd1,
        ST_EXT_HOLD = 3'd2,
        ST_RUN = 3'd3,
        ST_STOP = 3'd4
    } vs_state_e;

    typedef enum logic [1:0] {
        LP_RUN = 2'd0,
        LP_STOP2 = 2'd1,
        LP_STOP3 = 2'd2,
        LP_STOP4 = 2'd3
    } lp_mode_e;
endpackage

// File: rtl/vsup_sync.sv
module vsup_sync #(
    parameter int N = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_ni) begin
                if (!rst_ni) stg[0] <= '1;
                else         stg[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_ni) begin
                if (!rst_ni) stg[s] <= '1;
                else         stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vsup_fsm.sv
module vsup_fsm
    import vsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_ni,
    input  logic [N_CMP-1:0] syn_i,
    input  logic             det_en_i,
    input  logic             rst_en_i,
    input  logic             keep_i,
    input  logic             sel_hi_i,
    input  logic             ext_rst_i,
    input  logic             stop_req_i,
    input  logic [1:0]       stop_depth_i,
    input  logic             wake_i,
    output logic             det_evt_o,
    output logic             det_on_o,
    output logic             sys_rst_o,
    output logic             in_por_o,
    output logic [1:0]       lp_mode_o,
    output logic [2:0]       cause_o
);
    vs_state_e state_q, state_d;
    lp_mode_e  mode_q, mode_d;
    logic [2:0] cause_q, cause_d;
    logic      prev_q;
    logic      syn_sel;

    function automatic lp_mode_e pick_mode(input logic [1:0] depth, input logic survive);
        lp_mode_e m;
        if (depth[1])         m = LP_STOP4;
        else if (survive)     m = LP_STOP4;
        else if (depth[0])    m = LP_STOP3;
        else                  m = LP_STOP2;
        return m;
    endfunction

    assign syn_sel   = sel_hi_i ? syn_i[CMP_HI] : syn_i[CMP_LO];
    assign det_on_o  = det_en_i && ((state_q == ST_RUN) ||
                                    ((state_q == ST_STOP) && (mode_q == LP_STOP4)));
    assign det_evt_o = det_on_o && syn_sel && !prev_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_POR_HOLD;
            mode_q  <= LP_RUN;
            cause_q <= CAUSE_POR;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            cause_q <= cause_d;
            prev_q  <= syn_sel;
        end
    end

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        cause_d = cause_q;
        if (syn_i[CMP_REARM]) begin
            state_d = ST_POR_HOLD;
            cause_d = CAUSE_POR;
        end else begin
            unique case (state_q)
                ST_POR_HOLD: if (!syn_i[CMP_LO]) state_d = ST_RUN;
                ST_LVD_HOLD: if (!syn_sel)       state_d = ST_RUN;
                ST_EXT_HOLD: if (!ext_rst_i)     state_d = ST_RUN;
                ST_RUN, ST_STOP: begin
                    if (det_evt_o && rst_en_i) begin
                        state_d = ST_LVD_HOLD;
                        cause_d = CAUSE_LVD;
                    end else if (ext_rst_i) begin
                        state_d = ST_EXT_HOLD;
                        cause_d = CAUSE_EXT;
                    end else if (state_q == ST_RUN && stop_req_i) begin
                        state_d = ST_STOP;
                        mode_d  = pick_mode(stop_depth_i, det_en_i && keep_i);
                    end else if (state_q == ST_STOP && wake_i) begin
                        state_d = ST_RUN;
                    end
                end
                default: state_d = ST_POR_HOLD;
            endcase
        end
    end

    always_comb begin
        sys_rst_o = 1'b0;
        in_por_o  = 1'b0;
        lp_mode_o = LP_RUN;
        unique case (state_q)
            ST_POR_HOLD: begin
                sys_rst_o = 1'b1;
                in_por_o  = 1'b1;
            end
            ST_LVD_HOLD, ST_EXT_HOLD: sys_rst_o = 1'b1;
            ST_STOP: lp_mode_o = mode_q;
            default: lp_mode_o = LP_RUN;
        endcase
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/vsup_regs.sv
module vsup_regs
    import vsup_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              in_por_i,
    input  logic              hold_i,
    input  logic              det_evt_i,
    input  logic [2:0]        cause_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              we_i,
    input  logic [BUS_DW-1:0] wdata_i,
    output logic [BUS_DW-1:0] rdata_o,
    output logic              det_en_o,
    output logic              rst_en_o,
    output logic              irq_en_o,
    output logic              keep_o,
    output logic              sel_hi_o,
    output logic              flag_o
);
    logic wr_ctrl, wr_sel, set_flag;
    logic unused_wbits;

    assign wr_ctrl  = we_i && (addr_i == AW'(ADR_CTRL));
    assign wr_sel   = we_i && (addr_i == AW'(ADR_SEL));
    assign set_flag = det_evt_i && irq_en_o && !rst_en_o;
    assign unused_wbits = ^{wdata_i[7], wdata_i[5:4]};

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            det_en_o <= 1'b1;
            rst_en_o <= 1'b1;
            irq_en_o <= 1'b0;
            keep_o   <= 1'b0;
            sel_hi_o <= 1'b0;
            flag_o   <= 1'b0;
        end else if (in_por_i) begin
            det_en_o <= 1'b1;
            rst_en_o <= 1'b1;
            irq_en_o <= 1'b0;
            keep_o   <= 1'b0;
            sel_hi_o <= 1'b0;
            flag_o   <= 1'b0;
        end else if (hold_i) begin
            flag_o <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                det_en_o <= wdata_i[B_DET_EN];
                rst_en_o <= wdata_i[B_RST_EN];
                irq_en_o <= wdata_i[B_IRQ_EN];
                keep_o   <= wdata_i[B_KEEP];
            end
            if (wr_sel) sel_hi_o <= wdata_i[0];
            if (set_flag)                        flag_o <= 1'b1;
            else if (wr_ctrl && wdata_i[B_ACK])  flag_o <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            AW'(ADR_CTRL): begin
                rdata_o[B_FLAG]   = flag_o;
                rdata_o[B_KEEP]   = keep_o;
                rdata_o[B_IRQ_EN] = irq_en_o;
                rdata_o[B_RST_EN] = rst_en_o;
                rdata_o[B_DET_EN] = det_en_o;
            end
            AW'(ADR_SEL):   rdata_o[0] = sel_hi_o;
            AW'(ADR_CAUSE): rdata_o[2:0] = cause_i;
            default:        rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/vsup_ctrl.sv
module vsup_ctrl
    import vsup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW = 2
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              cmp_below_rearm_i,
    input  logic              cmp_below_hi_i,
    input  logic              cmp_below_lo_i,
    input  logic              ext_rst_req_i,
    input  logic              stop_req_i,
    input  logic [1:0]        stop_depth_i,
    input  logic              wake_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              sys_rst_o,
    output logic [1:0]        lp_mode_o,
    output logic              det_on_o
);
    logic [N_CMP-1:0] cmp_raw, cmp_syn;
    logic det_en_w, rst_en_w, irq_en_w, keep_w, sel_hi_w, flag_w;
    logic det_evt_w, in_por_w;
    logic [2:0] cause_w;

    always_comb begin
        cmp_raw = '0;
        cmp_raw[CMP_REARM] = cmp_below_rearm_i;
        cmp_raw[CMP_HI]    = cmp_below_hi_i;
        cmp_raw[CMP_LO]    = cmp_below_lo_i;
    end

    vsup_sync #(.N(N_CMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_ni(rst_ni), .d_i(cmp_raw), .q_o(cmp_syn)
    );

    vsup_fsm u_fsm (
        .clk(clk), .rst_ni(rst_ni), .syn_i(cmp_syn),
        .det_en_i(det_en_w), .rst_en_i(rst_en_w), .keep_i(keep_w), .sel_hi_i(sel_hi_w),
        .ext_rst_i(ext_rst_req_i), .stop_req_i(stop_req_i), .stop_depth_i(stop_depth_i),
        .wake_i(wake_i), .det_evt_o(det_evt_w), .det_on_o(det_on_o),
        .sys_rst_o(sys_rst_o), .in_por_o(in_por_w), .lp_mode_o(lp_mode_o), .cause_o(cause_w)
    );

    vsup_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_ni(rst_ni), .in_por_i(in_por_w), .hold_i(sys_rst_o),
        .det_evt_i(det_evt_w), .cause_i(cause_w), .addr_i(bus_addr_i), .we_i(bus_we_i),
        .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .det_en_o(det_en_w),
        .rst_en_o(rst_en_w), .irq_en_o(irq_en_w), .keep_o(keep_w), .sel_hi_o(sel_hi_w),
        .flag_o(flag_w)
    );

    assign irq_o = flag_w && irq_en_w;
endmodule

// File: rtl/vsup_ctrl_chk.sv
module vsup_ctrl_chk (
    input logic       clk,
    input logic       rst_ni,
    input logic       sys_rst_o,
    input logic       irq_o,
    input logic [1:0] lp_mode_o,
    input logic       det_on_o,
    input logic [1:0] bus_addr_i,
    input logic [7:0] bus_rdata_o,
    input logic [2:0] cause_w,
    input logic       det_en_w,
    input logic       sel_hi_w
);
    assert_det_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        det_on_o |-> det_en_w);

    assert_deep_stop_off_R4: assert property (@(posedge clk) disable iff (!rst_ni)
        (lp_mode_o == 2'd1 || lp_mode_o == 2'd2) |-> !det_on_o);

    assert_stop4_alive_R5: assert property (@(posedge clk) disable iff (!rst_ni)
        (lp_mode_o == 2'd3 && det_en_w) |-> det_on_o);

    assert_reset_no_lowpower_R12: assert property (@(posedge clk) disable iff (!rst_ni)
        sys_rst_o |-> lp_mode_o == 2'd0);

    assert_cause_valid_R8: assert property (@(posedge clk) disable iff (!rst_ni)
        (cause_w == 3'b110 || cause_w == 3'b010 || cause_w == 3'b001));

    assert_flag_dropped_by_reset_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(sys_rst_o) |=> !irq_o);

    assert_ack_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_ni)
        (bus_addr_i == 2'd0) |-> !bus_rdata_o[6]);

    assert_writes_blocked_R13: assert property (@(posedge clk) disable iff (!rst_ni)
        (sys_rst_o && $past(sys_rst_o) && !cause_w[2]) |-> $stable(sel_hi_w));
endmodule

bind vsup_ctrl vsup_ctrl_chk u_chk (
    .clk(clk), .rst_ni(rst_ni), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
    .lp_mode_o(lp_mode_o), .det_on_o(det_on_o), .bus_addr_i(bus_addr_i),
    .bus_rdata_o(bus_rdata_o), .cause_w(cause_w), .det_en_w(det_en_w), .sel_hi_w(sel_hi_w)
);

// File: tb/vsup_ctrl_bench.sv
module vsup_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic c_rearm = 1'b1, c_hi = 1'b1, c_lo = 1'b1;
    logic ext = 1'b0, sreq = 1'b0, wake = 1'b0, we = 1'b0;
    logic [1:0] depth = 2'd0, addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic irq, srst, don;
    logic [1:0] lp;

    int checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    vsup_ctrl u_vsup_ctrl (
        .clk(clk), .rst_ni(rst_n), .cmp_below_rearm_i(c_rearm), .cmp_below_hi_i(c_hi),
        .cmp_below_lo_i(c_lo), .ext_rst_req_i(ext), .stop_req_i(sreq), .stop_depth_i(depth),
        .wake_i(wake), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst), .lp_mode_o(lp), .det_on_o(don)
    );

    // behavioural reference model
    bit m1[3], m2[3];
    bit mprev, mde, mre, mie, mkp, msh, mflag, mok;
    int mst, mmode, mstat;

    always @(posedge clk) begin
        bit sel, hold, mon, ev;
        int nst, nmode, nstat;
        if (!rst_n) begin
            foreach (m1[i]) begin m1[i] = 1'b1; m2[i] = 1'b1; end
            mprev = 1; mst = 0; mmode = 0; mstat = 6;
            mde = 1; mre = 1; mie = 0; mkp = 0; msh = 0; mflag = 0; mok = 1;
        end else begin
            sel  = msh ? m2[1] : m2[2];
            hold = (mst < 3);
            mon  = mde && (mst == 3 || (mst == 4 && mmode == 3));
            ev   = mon && sel && !mprev;
            nst = mst; nmode = mmode; nstat = mstat;
            if (m2[0]) begin nst = 0; nstat = 6; end
            else if (mst == 0) begin if (!m2[2]) nst = 3; end
            else if (mst == 1) begin if (!sel) nst = 3; end
            else if (mst == 2) begin if (!ext) nst = 3; end
            else if (ev && mre) begin nst = 1; nstat = 2; end
            else if (ext) begin nst = 2; nstat = 1; end
            else if (mst == 3 && sreq) begin
                nst = 4;
                nmode = (depth >= 2) ? 3 : (mde && mkp) ? 3 : (depth == 1) ? 2 : 1;
            end
            else if (mst == 4 && wake) nst = 3;
            if (mst == 0) begin
                mde = 1; mre = 1; mie = 0; mkp = 0; msh = 0; mflag = 0;
            end else if (hold) begin
                mflag = 0;
            end else begin
                if (ev && mie && !mre) mflag = 1;
                else if (we && addr == 0 && wdata[6]) mflag = 0;
                if (we && addr == 0) begin
                    mde = wdata[0]; mre = wdata[1]; mie = wdata[2]; mkp = wdata[3];
                end
                if (we && addr == 1) msh = wdata[0];
            end
            mst = nst; mmode = nmode; mstat = nstat; mprev = sel;
            m2 = m1; m1[0] = c_rearm; m1[1] = c_hi; m1[2] = c_lo;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return (int'(mflag) << 7) | (int'(mkp) << 3) | (int'(mie) << 2) | (int'(mre) << 1) | int'(mde);
            1: return int'(msh);
            2: return mstat;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mok && rst_n) begin
            check("R1 R6 R7 R11 sys_rst", int'(srst), int'(mst < 3));
            check("R9 R10 irq", int'(irq), int'(mflag && mie));
            check("R4 R5 R12 lp_mode", int'(lp), (mst == 4) ? mmode : 0);
            check("R3 R5 det_on", int'(don), int'(mde && (mst == 3 || (mst == 4 && mmode == 3))));
            check("R2 R8 R13 rdata", int'(rdata), exp_rd(int'(addr)));
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cyc);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        step(1); addr = 2'(a); wdata = 8'(d); we = 1'b1;
        step(1); we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        addr = 2'(a); #3;
        check(tag, int'(rdata), exp);
    endtask

    task automatic do_stop(input int d);
        sreq = 1'b1; depth = 2'(d); step(1); sreq = 1'b0;
    endtask

    task automatic do_wake();
        wake = 1'b1; step(1); wake = 1'b0; step(1);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        step(3); rst_n = 1'b1;
        step(4); check("R6 held at power-up", int'(srst), 1);
        rd(2, 6, "R8 cause after power-up");
        c_rearm = 1'b0; step(6); check("R6 still held below low trip", int'(srst), 1);
        c_hi = 1'b0; c_lo = 1'b0; step(6); check("R6 released", int'(srst), 0);
        rd(0, 3, "R6 control defaults");
        // R1 / R7 low-voltage reset timing
        c_lo = 1'b1; step(2); check("R1 not yet at edge two", int'(srst), 0);
        step(1); check("R1 reset on edge three", int'(srst), 1);
        rd(2, 2, "R8 cause lvd");
        step(10); check("R7 held while below", int'(srst), 1);
        c_lo = 1'b0; step(6); check("R7 released", int'(srst), 0);
        // R2 high threshold
        wr(1, 1); c_lo = 1'b1; step(6); check("R2 low comparator ignored", int'(srst), 0);
        c_hi = 1'b1; step(6); check("R2 high trip resets", int'(srst), 1);
        c_hi = 1'b0; c_lo = 1'b0; step(6); wr(1, 0);
        // R9 / R10 interrupt
        wr(0, 8'h05); c_lo = 1'b1; step(6); check("R9 irq raised", int'(irq), 1);
        rd(0, 8'h85, "R9 flag readback");
        wr(0, 8'h45); check("R10 ack clears", int'(irq), 0);
        rd(0, 8'h05, "R10 ack reads zero");
        step(8); check("R1 held level no retrigger", int'(irq), 0);
        c_lo = 1'b0; step(5);
        // R3 detector disabled
        wr(0, 8'h04); c_lo = 1'b1; step(6);
        check("R3 no irq when disabled", int'(irq), 0);
        check("R3 det_on low", int'(don), 0);
        c_lo = 1'b0; step(4);
        // R4 / R12 stop modes
        wr(0, 8'h01); do_stop(0); step(2);
        check("R4 stop2", int'(lp), 1); check("R4 detector off", int'(don), 0);
        do_wake(); check("R12 wake to run", int'(lp), 0);
        do_stop(1); step(2); check("R4 stop3", int'(lp), 2); do_wake();
        // R5 stop promotion
        wr(0, 8'h09); do_stop(1); step(2);
        check("R5 promoted to stop4", int'(lp), 3); check("R5 detector kept", int'(don), 1);
        do_wake();
        wr(0, 8'h0B); do_stop(0); step(2); check("R5 stop4 again", int'(lp), 3);
        c_lo = 1'b1; step(5);
        check("R5 reset from stop4", int'(srst), 1); check("R12 mode run in reset", int'(lp), 0);
        c_lo = 1'b0; step(6);
        // R11 / R13 external reset
        ext = 1'b1; step(3); check("R11 ext held", int'(srst), 1);
        wr(1, 1);
        ext = 1'b0; step(4); check("R11 ext released", int'(srst), 0);
        rd(2, 1, "R11 cause ext");
        rd(1, 0, "R13 write ignored in reset");
        rd(0, 8'h0B, "R11 controls kept");
        // R6 re-arm while running
        c_rearm = 1'b1; step(5); check("R6 rearm resets", int'(srst), 1);
        rd(0, 3, "R6 defaults restored"); rd(2, 6, "R8 cause por");
        c_rearm = 1'b0; step(6); check("R6 rearm released", int'(srst), 0);
        // stop4 request with detector off
        wr(0, 0); do_stop(2); step(2);
        check("R5 stop4 request", int'(lp), 3); check("R3 det_on off in stop4", int'(don), 0);
        do_wake(); step(3);
        finish_run();
    end
endmodule